// File: doc/BRIEF.md
# Single-Accumulator Stored-Program Processor

This block is a small processor with one shared memory for both program and data. It keeps a single 16-bit working register, the accumulator. Every instruction is one 16-bit word that carries an operation code and a direct 12-bit memory address. The core fetches each word, decodes it and executes it through a fixed three-step state sequence. It can load, store, add, mask with AND, invert the accumulator, jump, branch when the accumulator is negative, and halt.

The memory sits outside the block on a single-port bus. The bus has a 12-bit address, separate read and write data, and a write strobe. A read returns its data one clock after the address is presented, which is how a synchronous RAM behaves. Debug outputs show the program counter, the accumulator and whether the core has halted.

Top module: `acc_cpu`

## Requirements
- R1: While `rst_n` is low at a clock edge, the program counter and accumulator become 0, `dbg_halted` and `mem_we` are 0, and the core starts a fetch from address 0 once reset is released.
- R2: Each instruction except halt takes exactly three clocks. In the first clock `mem_addr` equals the program counter. The program counter shows the next address after the second clock, and the instruction's effect is visible after the third clock.
- R3: Opcode 0x0 (word bits [15:12]) loads the accumulator with the memory word at the address in bits [11:0].
- R4: Opcode 0x1 writes the accumulator to the word at bits [11:0]. It raises `mem_we` for exactly one clock and changes no other memory word.
- R5: Opcode 0x2 adds the addressed word to the accumulator modulo 2^16, and the carry out is lost.
- R6: Opcode 0x3 replaces the accumulator with its bitwise AND with the addressed word.
- R7: Opcode 0x6 replaces the accumulator with its bitwise complement.
- R8: Opcode 0x4 sets the program counter to bits [11:0].
- R9: Opcode 0x5 sets the program counter to bits [11:0] when accumulator bit 15 is 1. When that bit is 0, the program counter simply moves on to the next word.
- R10: Opcodes 0x7 to 0xE leave the accumulator and memory unchanged and only advance the program counter.
- R11: The program counter steps modulo 4096, so execution continues at 0x000 after 0xFFF.
- R12: Opcode 0xF halts the core. While halted, `dbg_halted` is 1, the program counter and accumulator hold their values, and no write occurs until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 12 | Memory word address |
| mem_rdata | input | 16 | Read data, valid one clock after its address |
| mem_wdata | output | 16 | Write data (the accumulator) |
| mem_we | output | 1 | Write strobe for `mem_addr` |
| dbg_pc | output | 12 | Program counter |
| dbg_acc | output | 16 | Accumulator |
| dbg_halted | output | 1 | Core has executed a halt |

## Verification
The embedded assertions check the following on every cycle:
- The fetch, decode and execute order of the state machine.
- The single-cycle write strobe.
- That the accumulator changes only in an execute step.
- That the program counter steps by one after a decode, with wrap-around.
- That the program counter takes the jump target.
- That the program counter is not redirected on an untaken branch.
- That the halted state freezes the core.

The directed scenarios are the only way to show the arithmetic and logic results against hand-computed values. They also check the exact cycle at which each effect appears, that a store touches only its addressed word, that unused opcodes leave memory untouched, and that execution wraps from the top of memory to address 0.

// File: rtl/acc_cpu_pkg.sv
// Shared definitions for the accumulator processor.
// Assumes the opcode occupies the top four bits of every instruction word.
package acc_cpu_pkg;

    localparam int OPC_W = 4;

    typedef enum logic [OPC_W-1:0] {
        OP_LOAD  = 4'h0,
        OP_STORE = 4'h1,
        OP_ADD   = 4'h2,
        OP_AND   = 4'h3,
        OP_JMP   = 4'h4,
        OP_BRNA  = 4'h5,
        OP_CMPA  = 4'h6,
        OP_HALT  = 4'hF
    } opcode_t;

    typedef enum logic [1:0] {
        ST_FETCH  = 2'd0,
        ST_DECODE = 2'd1,
        ST_EXEC   = 2'd2,
        ST_HALT   = 2'd3
    } cpu_state_t;

endpackage

// File: rtl/acc_cpu_ctrl.sv
// Sequencer for the accumulator processor.
// Steps FETCH -> DECODE -> EXEC and latches the instruction word in DECODE.
// In EXEC it issues the accumulator, program-counter and memory-write strobes.
// Assumes the read data in DECODE is the word that was addressed in FETCH.
module acc_cpu_ctrl
    import acc_cpu_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              acc_neg,
    output cpu_state_t        state,
    output opcode_t           ir_op,
    output logic [ADDR_W-1:0] ir_addr,
    output logic              pc_step,
    output logic              pc_jump,
    output logic              acc_we,
    output logic              mem_we
);

    localparam int OPC_LSB = DATA_W - OPC_W;

    cpu_state_t        state_q, state_d;
    opcode_t           ir_op_q;
    logic [ADDR_W-1:0] ir_addr_q;
    logic              in_exec;

    // Next-state selection for the instruction sequence.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_FETCH:  state_d = ST_DECODE;
            ST_DECODE: state_d = ST_EXEC;
            ST_EXEC:   state_d = (ir_op_q == OP_HALT) ? ST_HALT : ST_FETCH;
            default:   state_d = ST_HALT;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FETCH;
        else        state_q <= state_d;
    end

    // Instruction register, loaded from the read data during DECODE.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_op_q   <= OP_LOAD;
            ir_addr_q <= '0;
        end else if (state_q == ST_DECODE) begin
            ir_op_q   <= opcode_t'(mem_rdata[DATA_W-1:OPC_LSB]);
            ir_addr_q <= mem_rdata[ADDR_W-1:0];
        end
    end

    assign in_exec = (state_q == ST_EXEC);

    // Per-opcode strobes, active only during EXEC.
    always_comb begin
        acc_we  = 1'b0;
        mem_we  = 1'b0;
        pc_jump = 1'b0;
        if (in_exec) begin
            case (ir_op_q)
                OP_LOAD, OP_ADD, OP_AND, OP_CMPA: acc_we  = 1'b1;
                OP_STORE:                         mem_we  = 1'b1;
                OP_JMP:                           pc_jump = 1'b1;
                OP_BRNA:                          pc_jump = acc_neg;
                default: ;
            endcase
        end
    end

    assign pc_step = (state_q == ST_DECODE);
    assign state   = state_q;
    assign ir_op   = ir_op_q;
    assign ir_addr = ir_addr_q;

    // R2
    fetch_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH) |=> (state_q == ST_DECODE));
    // R2
    decode_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DECODE) |=> (state_q == ST_EXEC));
    // R12
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT) |=> (state_q == ST_HALT));

endmodule

// File: rtl/acc_cpu_pc.sv
// Program counter for the accumulator processor.
// Steps by one with natural wrap, or loads a jump target.
// Assumes step and jump are never active in the same cycle.
module acc_cpu_pc #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              jump,
    input  logic [ADDR_W-1:0] target,
    output logic [ADDR_W-1:0] pc
);

    logic [ADDR_W-1:0] pc_q;

    // Counter register; the increment wraps modulo 2^ADDR_W.
    always_ff @(posedge clk) begin
        if (!rst_n)     pc_q <= '0;
        else if (jump)  pc_q <= target;
        else if (step)  pc_q <= pc_q + 1'b1;
    end

    assign pc = pc_q;

    // R11
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (pc_q == ADDR_W'($past(pc_q) + 1'b1)));
    // R8
    pc_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        jump |=> (pc_q == $past(target)));
    // R12
    pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !jump) |=> $stable(pc_q));

endmodule

// File: rtl/acc_cpu_alu.sv
// Combinational accumulator datapath.
// Produces the new accumulator value for the given opcode.
// Assumes the caller gates the result with its own write strobe.
module acc_cpu_alu
    import acc_cpu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  opcode_t           op,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] operand,
    output logic [DATA_W-1:0] result
);

    // Result selection; the sum drops its carry out.
    always_comb begin
        case (op)
            OP_LOAD: result = operand;
            OP_ADD:  result = acc + operand;
            OP_AND:  result = acc & operand;
            OP_CMPA: result = ~acc;
            default: result = acc;
        endcase
    end

endmodule

// File: rtl/acc_cpu.sv
// Accumulator processor top level.
// Holds the accumulator and steers the single-port memory address.
// Assumes memory read data lags its address by exactly one clock.
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic [ADDR_W-1:0] dbg_pc,
    output logic [DATA_W-1:0] dbg_acc,
    output logic              dbg_halted
);

    localparam int SIGN_BIT = DATA_W - 1;

    cpu_state_t        state;
    opcode_t           ir_op;
    logic [ADDR_W-1:0] ir_addr;
    logic [ADDR_W-1:0] pc;
    logic              pc_step, pc_jump, acc_we, wr_strobe;
    logic [DATA_W-1:0] acc_q, alu_res;

    acc_cpu_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_rdata (mem_rdata),
        .acc_neg   (acc_q[SIGN_BIT]),
        .state     (state),
        .ir_op     (ir_op),
        .ir_addr   (ir_addr),
        .pc_step   (pc_step),
        .pc_jump   (pc_jump),
        .acc_we    (acc_we),
        .mem_we    (wr_strobe)
    );

    acc_cpu_pc #(.ADDR_W(ADDR_W)) u_pc (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (pc_step),
        .jump   (pc_jump),
        .target (ir_addr),
        .pc     (pc)
    );

    acc_cpu_alu #(.DATA_W(DATA_W)) u_alu (
        .op      (ir_op),
        .acc     (acc_q),
        .operand (mem_rdata),
        .result  (alu_res)
    );

    // Accumulator register.
    always_ff @(posedge clk) begin
        if (!rst_n)      acc_q <= '0;
        else if (acc_we) acc_q <= alu_res;
    end

    // Address steering: PC in fetch, operand field straight from memory in decode.
    always_comb begin
        case (state)
            ST_DECODE: mem_addr = mem_rdata[ADDR_W-1:0];
            ST_EXEC:   mem_addr = ir_addr;
            default:   mem_addr = pc;
        endcase
    end

    assign mem_we     = wr_strobe;
    assign mem_wdata  = acc_q;
    assign dbg_pc     = pc;
    assign dbg_acc    = acc_q;
    assign dbg_halted = (state == ST_HALT);

    // R4
    we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);
    // R10
    acc_exec_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(acc_q) |-> $past(state == ST_EXEC));
    // R12
    halt_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_halted |=> (dbg_halted && $stable(acc_q) && !mem_we));
    // R9
    brna_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && ir_op == OP_BRNA && !acc_q[SIGN_BIT])
        |=> (pc == $past(pc)));

endmodule

// File: tb/test_acc_cpu.sv
`timescale 1ns/1ps
module test_acc_cpu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] mem_addr;
    logic [15:0] mem_rdata;
    logic [15:0] mem_wdata;
    logic        mem_we;
    logic [11:0] dbg_pc;
    logic [15:0] dbg_acc;
    logic        dbg_halted;

    logic [15:0] mem [4096];
    logic        ld_clr = 1'b0;
    logic        ld_we = 1'b0;
    logic [11:0] ld_addr = '0;
    logic [15:0] ld_data = '0;
    int          wr_cnt = 0;
    int          n_chk = 0;
    int          n_err = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    acc_cpu i_acc_cpu (
        .clk        (clk),
        .rst_n      (rst_n),
        .mem_addr   (mem_addr),
        .mem_rdata  (mem_rdata),
        .mem_wdata  (mem_wdata),
        .mem_we     (mem_we),
        .dbg_pc     (dbg_pc),
        .dbg_acc    (dbg_acc),
        .dbg_halted (dbg_halted)
    );

    // Synchronous single-port memory model plus loader.
    always @(posedge clk) begin
        if (ld_clr) begin
            for (int i = 0; i < 4096; i++) mem[i] <= '0;
        end else if (ld_we) begin
            mem[ld_addr] <= ld_data;
        end else if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        mem_rdata <= mem[mem_addr];
    end

    function automatic logic [15:0] ins(logic [3:0] op, logic [11:0] a);
        return {op, a};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic begin_prog();
        rst_n = 1'b0;
        @(negedge clk); ld_clr = 1'b1;
        @(negedge clk); ld_clr = 1'b0;
    endtask

    task automatic put(logic [11:0] a, logic [15:0] d);
        @(negedge clk);
        ld_we = 1'b1; ld_addr = a; ld_data = d;
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    task automatic release_rst();
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic edges(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wait_halt(string req, int limit);
        int k = 0;
        while (!dbg_halted && k < limit) begin
            @(negedge clk);
            k++;
        end
        chk({req, " halt reached"}, {31'd0, dbg_halted}, 32'd1);
    endtask

    // R1 reset values and R2 cycle timing of a single load.
    task automatic t_reset_timing();
        begin_prog();
        put(12'h000, ins(4'h0, 12'h100));
        put(12'h100, 16'hBEEF);
        edges(2);
        chk("R1 pc", dbg_pc, 0);
        chk("R1 acc", dbg_acc, 0);
        chk("R1 halted", dbg_halted, 0);
        chk("R1 we", mem_we, 0);
        release_rst();
        chk("R2 fetch addr", mem_addr, 12'h000);
        edges(1);
        chk("R2 pc after fetch", dbg_pc, 12'h000);
        edges(1);
        chk("R2 pc after decode", dbg_pc, 12'h001);
        chk("R2 acc before exec", dbg_acc, 16'h0000);
        edges(1);
        chk("R3 load acc", dbg_acc, 16'hBEEF);
        chk("R2 next fetch addr", mem_addr, 12'h001);
    endtask

    // R3..R7 data operations and stores.
    task automatic t_alu();
        int w0;
        begin_prog();
        put(12'h000, ins(4'h0, 12'h200));
        put(12'h001, ins(4'h2, 12'h201));
        put(12'h002, ins(4'h1, 12'h210));
        put(12'h003, ins(4'h0, 12'h200));
        put(12'h004, ins(4'h3, 12'h201));
        put(12'h005, ins(4'h1, 12'h211));
        put(12'h006, ins(4'h0, 12'h200));
        put(12'h007, ins(4'h6, 12'h000));
        put(12'h008, ins(4'h1, 12'h212));
        put(12'h009, ins(4'hF, 12'h000));
        put(12'h200, 16'h8001);
        put(12'h201, 16'h8003);
        put(12'h213, 16'h5A5A);
        w0 = wr_cnt;
        release_rst();
        wait_halt("R3", 200);
        chk("R5 add wraps", mem[12'h210], 16'h0004);
        chk("R6 and", mem[12'h211], 16'h8001);
        chk("R7 complement", mem[12'h212], 16'h7FFE);
        chk("R7 final acc", dbg_acc, 16'h7FFE);
        chk("R4 neighbour untouched", mem[12'h213], 16'h5A5A);
        chk("R4 write count", wr_cnt - w0, 3);
        chk("R3 source intact", mem[12'h200], 16'h8001);
    endtask

    // R8 jump, R9 branch taken and not taken.
    task automatic t_branch();
        begin_prog();
        put(12'h000, ins(4'h4, 12'h040));
        put(12'h001, ins(4'hF, 12'h000));
        put(12'h040, ins(4'h0, 12'h300));
        put(12'h041, ins(4'h5, 12'h080));
        put(12'h042, ins(4'hF, 12'h000));
        put(12'h080, ins(4'h0, 12'h301));
        put(12'h081, ins(4'h5, 12'h0C0));
        put(12'h082, ins(4'hF, 12'h000));
        put(12'h0C0, ins(4'hF, 12'h000));
        put(12'h300, 16'hF000);
        put(12'h301, 16'h7FFF);
        release_rst();
        edges(3);
        chk("R8 jump target", dbg_pc, 12'h040);
        edges(6);
        chk("R9 taken branch", dbg_pc, 12'h080);
        wait_halt("R9", 200);
        chk("R9 not taken stops at next", dbg_pc, 12'h083);
        chk("R9 acc", dbg_acc, 16'h7FFF);
    endtask

    // R10 unused opcodes do nothing.
    task automatic t_noop();
        int w0;
        begin_prog();
        put(12'h000, ins(4'h0, 12'h300));
        put(12'h001, ins(4'h7, 12'h300));
        put(12'h002, ins(4'hE, 12'h301));
        put(12'h003, ins(4'hA, 12'h302));
        put(12'h004, ins(4'hF, 12'h000));
        put(12'h300, 16'h1234);
        put(12'h301, 16'h0F0F);
        w0 = wr_cnt;
        release_rst();
        edges(6);
        chk("R10 acc after 0x7", dbg_acc, 16'h1234);
        chk("R10 pc after 0x7", dbg_pc, 12'h002);
        wait_halt("R10", 200);
        chk("R10 acc", dbg_acc, 16'h1234);
        chk("R10 pc", dbg_pc, 12'h005);
        chk("R10 no writes", wr_cnt - w0, 0);
        chk("R10 mem 300", mem[12'h300], 16'h1234);
        chk("R10 mem 301", mem[12'h301], 16'h0F0F);
    endtask

    // R11 wrap from the top of memory to address 0.
    task automatic t_wrap();
        begin_prog();
        put(12'h000, ins(4'h4, 12'hFFF));
        put(12'hFFF, ins(4'h6, 12'h000));
        release_rst();
        edges(3);
        chk("R11 at top", dbg_pc, 12'hFFF);
        edges(2);
        chk("R11 wrapped pc", dbg_pc, 12'h000);
        edges(1);
        chk("R11 acc after top instr", dbg_acc, 16'hFFFF);
        chk("R11 fetch addr", mem_addr, 12'h000);
    endtask

    // R12 halt freezes the core until reset.
    task automatic t_halt();
        int w0;
        begin_prog();
        put(12'h000, ins(4'h0, 12'h300));
        put(12'h001, ins(4'hF, 12'h000));
        put(12'h002, ins(4'h1, 12'h300));
        put(12'h300, 16'h00AA);
        w0 = wr_cnt;
        release_rst();
        edges(6);
        chk("R12 halted on time", dbg_halted, 1);
        edges(20);
        chk("R12 still halted", dbg_halted, 1);
        chk("R12 pc frozen", dbg_pc, 12'h002);
        chk("R12 acc frozen", dbg_acc, 16'h00AA);
        chk("R12 no writes", wr_cnt - w0, 0);
        rst_n = 1'b0;
        edges(1);
        chk("R1 reset clears halt", dbg_halted, 0);
        chk("R1 reset clears acc", dbg_acc, 16'h0000);
    endtask

    initial begin
        t_reset_timing();
        t_alu();
        t_branch();
        t_noop();
        t_wrap();
        t_halt();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule